// File: doc/BRIEF.md
# Conditional Branch Condition Evaluator

This unit sits in the execute stage of a scalar pipeline. For each conditional branch handed to it by the decoder, it decides whether the branch is taken and computes the branch destination. It covers three branch shapes:

- register against register, with an 8-bit displacement;
- register against a supplied constant or an immediate bit position, with an 8-bit displacement;
- register against zero, with a 12-bit displacement.

The branch shape arrives on a two-bit kind input. The register operand values, the constant for the immediate shape and the program counter of the branch are all supplied as inputs. The unit does not fetch, look up constant tables or drive the next-PC selector.

The verdict and the destination are registered once. A branch presented with its valid input high in one cycle therefore shows its outcome on the outputs in the following cycle. This models resolution late in the pipe, with operands read as late as possible. Condition codes that the unit does not define, a reserved kind, or a register-pair branch whose major opcode is not the branch major all raise an illegal flag and force the branch not taken.

Top module: `br_eval`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `br_taken`, `br_illegal` and `br_target` become 0 after that edge.
- R2: When `in_valid` is low in a cycle, `br_taken` and `br_illegal` are 0 in the next cycle, whatever the other inputs are.
- R3: For the register-pair kind (`in_kind`=0), with `in_major`=7, the condition nibble `in_r` selects the test of A=`in_opa` against B=`in_opb`:
  - 0 = (A&B)==0;
  - 1 = A==B;
  - 2 = signed A<B;
  - 3 = unsigned A<B;
  - 4 = (~A&B)==0;
  - 5 = bit of A clear.
  Code+8 takes the exact opposite verdict: 8 = (A&B)!=0, 9 = A!=B, A = signed A>=B, B = unsigned A>=B, C = (~A&B)!=0, D = bit of A set.
- R4: In the register-pair bit tests (codes 5 and D), the bit position is the low 5 bits of B. The upper bits of B do not affect the verdict.
- R5: For the register-pair kind, condition nibbles 6, 7, E and F give `br_taken`=0 and `br_illegal`=1.
- R6: For the register-pair and immediate kinds, `br_target` = `in_pc` + 4 + sign-extended `in_disp[7:0]`. Bits `in_disp[11:8]` are ignored for these kinds.
- R7: For the zero kind (`in_kind`=2), `in_zero_sel` picks the test on A: 0 = A==0, 1 = A!=0, 2 = signed A<0, 3 = signed A>=0. `br_target` = `in_pc` + 4 + sign-extended `in_disp[11:0]`.
- R8: For the immediate kind (`in_kind`=1), `in_imm_cond` uses the codes of R3 with C=`in_imm_val`. Only 1, 2, 3, 9, A and B compare A against C. Codes 5 (bit clear) and D (bit set) test bit {`in_bit4`,`in_r`} of A. All other codes give `br_illegal`=1 and `br_taken`=0.
- R9: The outputs show the verdict for the inputs sampled at the previous rising edge. Back-to-back branches resolve one per cycle.
- R10: A register-pair branch with `in_major` other than 7, or the reserved kind 3, gives `br_illegal`=1 and `br_taken`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A branch is presented this cycle |
| in_kind | input | 2 | Branch kind: 0 register pair, 1 immediate, 2 zero, 3 reserved |
| in_major | input | 4 | Major opcode field (7 required for register pair) |
| in_r | input | 4 | Condition nibble (register pair) or low bit position (immediate) |
| in_bit4 | input | 1 | Bit 4 of the immediate bit position |
| in_imm_cond | input | 4 | Condition code for the immediate kind |
| in_zero_sel | input | 2 | Test selector for the zero kind |
| in_disp | input | 12 | Branch displacement (low 8 bits for the 8-bit kinds) |
| in_opa | input | 32 | First register operand |
| in_opb | input | 32 | Second register operand |
| in_imm_val | input | 32 | Constant for the immediate compare |
| in_pc | input | 32 | Program counter of the branch |
| br_taken | output | 1 | Branch taken, registered |
| br_target | output | 32 | Branch destination, registered |
| br_illegal | output | 1 | Undefined condition or kind, registered |

## Verification
A wrong comparator flag, or a wrong decode of the inversion bit, shows as a flipped `br_taken` exactly one cycle after the offending branch. The paired codes, the signed-versus-unsigned operands (all ones against 1) and the bit-position operands whose upper bits are set are chosen so that each such fault changes at least one verdict. A wrong sign extension or base address shows in `br_target` in that same cycle. Displacements at both ends of the 8-bit and 12-bit ranges expose this, as does a nonzero upper nibble on an 8-bit branch. A stuck output register shows either as a missing reset value or as a verdict carried over into a following cycle with `in_valid` low.

// File: rtl/br_pkg.sv
// Package: shared types and constants for the branch condition evaluator.
// Assumes a single scalar pipeline with 32-bit addresses by default.
package br_pkg;

    // Branch shape supplied by the decoder
    typedef enum logic [1:0] {
        BK_REG  = 2'd0,
        BK_IMM  = 2'd1,
        BK_ZERO = 2'd2,
        BK_RSVD = 2'd3
    } br_kind_e;

    // Major opcode that register-pair and bit-test branches must carry
    localparam logic [3:0] BR_MAJOR = 4'h7;

    // Base test numbers (low three bits of a condition nibble)
    localparam logic [2:0] BT_NONE  = 3'd0;
    localparam logic [2:0] BT_EQ    = 3'd1;
    localparam logic [2:0] BT_LTS   = 3'd2;
    localparam logic [2:0] BT_LTU   = 3'd3;
    localparam logic [2:0] BT_ALL   = 3'd4;
    localparam logic [2:0] BT_BCLR  = 3'd5;

    // Zero-compare selectors
    localparam logic [1:0] ZS_EQ = 2'd0;
    localparam logic [1:0] ZS_NE = 2'd1;
    localparam logic [1:0] ZS_LT = 2'd2;
    localparam logic [1:0] ZS_GE = 2'd3;

    // Flags produced by one comparator
    typedef struct packed {
        logic eq;
        logic lts;
        logic ltu;
        logic none;
        logic allset;
        logic bitv;
    } cmp_flags_t;

endpackage

// File: rtl/br_cmp.sv
// Module: br_cmp
// Computes every relation a branch may test between two words:
// equality, signed and unsigned less-than, mask-none, mask-all and a
// selected bit of the first word. Purely combinational.
// Assumes BIDX_W bits are enough to index a W-bit word.
module br_cmp
    import br_pkg::*;
#(
    parameter int W      = 32,
    parameter int BIDX_W = $clog2(W)
) (
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    input  logic [BIDX_W-1:0] bidx,
    output cmp_flags_t        flags
);

    logic [W:0] diff;   // a - b with borrow in the top bit

    // Subtract once and derive both orderings from the borrow and signs
    always_comb begin
        diff = {1'b0, a} - {1'b0, b};
    end

    // Collect the relation flags
    always_comb begin
        flags.eq     = (a == b);
        flags.ltu    = diff[W];
        flags.lts    = (a[W-1] != b[W-1]) ? a[W-1] : diff[W];
        flags.none   = ((a & b) == '0);
        flags.allset = ((~a & b) == '0);
        flags.bitv   = a[bidx];
    end

endmodule

// File: rtl/br_cond_sel.sv
// Module: br_cond_sel
// Picks the verdict for the presented branch kind from the comparator
// flags and flags undefined encodings. Combinational.
// Assumes the register-pair flags compare A with B and the immediate
// flags compare A with the supplied constant, with the bit position
// already routed into each comparator.
module br_cond_sel
    import br_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [1:0]   kind,
    input  logic [3:0]   major,
    input  logic [3:0]   reg_cond,
    input  logic [3:0]   imm_cond,
    input  logic [1:0]   zero_sel,
    input  cmp_flags_t   reg_flags,
    input  cmp_flags_t   imm_flags,
    input  logic [W-1:0] opa,
    output logic         taken,
    output logic         illegal
);

    // Raw base test result before the inversion bit is applied
    function automatic logic base_test(input logic [2:0] code, input cmp_flags_t f);
        case (code)
            BT_NONE: base_test = f.none;
            BT_EQ:   base_test = f.eq;
            BT_LTS:  base_test = f.lts;
            BT_LTU:  base_test = f.ltu;
            BT_ALL:  base_test = f.allset;
            BT_BCLR: base_test = ~f.bitv;
            default: base_test = 1'b0;
        endcase
    endfunction

    logic reg_ok, reg_res;
    logic imm_ok, imm_res;
    logic zero_res;

    // Register-pair: base codes 0..5 legal, inversion by the top bit
    always_comb begin
        reg_ok  = (reg_cond[2:0] <= BT_BCLR) && (major == BR_MAJOR);
        reg_res = base_test(reg_cond[2:0], reg_flags) ^ reg_cond[3];
    end

    // Immediate: only compares (1,2,3) and the bit test (5) with inversion
    always_comb begin
        case (imm_cond[2:0])
            BT_EQ, BT_LTS, BT_LTU, BT_BCLR: imm_ok = 1'b1;
            default:                        imm_ok = 1'b0;
        endcase
        imm_res = base_test(imm_cond[2:0], imm_flags) ^ imm_cond[3];
    end

    // Zero compare on the first operand alone
    always_comb begin
        case (zero_sel)
            ZS_EQ:   zero_res = (opa == '0);
            ZS_NE:   zero_res = (opa != '0);
            ZS_LT:   zero_res = opa[W-1];
            default: zero_res = ~opa[W-1];
        endcase
    end

    // Select by kind; anything undefined is illegal and not taken
    always_comb begin
        taken   = 1'b0;
        illegal = 1'b0;
        case (br_kind_e'(kind))
            BK_REG: begin
                illegal = ~reg_ok;
                taken   = reg_ok & reg_res;
            end
            BK_IMM: begin
                illegal = ~imm_ok;
                taken   = imm_ok & imm_res;
            end
            BK_ZERO: begin
                taken   = zero_res;
            end
            default: begin
                illegal = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/br_target.sv
// Module: br_target
// Forms the branch destination: the address of the next instruction
// plus the sign-extended displacement. The wide flag selects the long
// displacement; otherwise only the low SHORT_W bits are used.
// Assumes instructions are INSN_BYTES long for the base address.
module br_target #(
    parameter int W          = 32,
    parameter int LONG_W     = 12,
    parameter int SHORT_W    = 8,
    parameter int INSN_BYTES = 4
) (
    input  logic [W-1:0]      pc,
    input  logic [LONG_W-1:0] disp,
    input  logic              wide,
    output logic [W-1:0]      target
);

    localparam int SEXT_L = W - LONG_W;
    localparam int SEXT_S = W - SHORT_W;

    logic [W-1:0] next_pc;
    logic [W-1:0] offs;

    // Base is the following instruction, not the branch itself
    always_comb begin
        next_pc = pc + W'(INSN_BYTES);
    end

    // Sign-extend the selected displacement width
    always_comb begin
        if (wide) begin
            offs = {{SEXT_L{disp[LONG_W-1]}}, disp};
        end else begin
            offs = {{SEXT_S{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
        end
    end

    // Add offset to base
    always_comb begin
        target = next_pc + offs;
    end

endmodule

// File: rtl/br_eval.sv
// Module: br_eval (top)
// Conditional branch evaluator: decides taken / not taken for three
// branch kinds and computes the destination. Verdict, destination and
// illegal flag are registered once, so results appear one cycle after
// the branch is presented. Synchronous active-low reset.
// Assumes the decoder supplies the kind, the fields and the operand
// values; the constant for the immediate kind comes in on in_imm_val.
module br_eval
    import br_pkg::*;
#(
    parameter int W       = 32,
    parameter int LONG_W  = 12,
    parameter int SHORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_kind,
    input  logic [3:0]        in_major,
    input  logic [3:0]        in_r,
    input  logic              in_bit4,
    input  logic [3:0]        in_imm_cond,
    input  logic [1:0]        in_zero_sel,
    input  logic [LONG_W-1:0] in_disp,
    input  logic [W-1:0]      in_opa,
    input  logic [W-1:0]      in_opb,
    input  logic [W-1:0]      in_imm_val,
    input  logic [W-1:0]      in_pc,
    output logic              br_taken,
    output logic [W-1:0]      br_target,
    output logic              br_illegal
);

    localparam int BIDX_W = $clog2(W);

    cmp_flags_t       reg_flags;
    cmp_flags_t       imm_flags;
    logic [BIDX_W-1:0] imm_bidx;
    logic             taken_d;
    logic             illegal_d;
    logic [W-1:0]     target_d;
    logic             wide;

    // Immediate bit position is split over the bit4 input and r nibble
    always_comb begin
        imm_bidx = BIDX_W'({in_bit4, in_r});
        wide     = (in_kind == BK_ZERO);
    end

    br_cmp #(.W(W), .BIDX_W(BIDX_W)) i_cmp_reg (
        .a     (in_opa),
        .b     (in_opb),
        .bidx  (in_opb[BIDX_W-1:0]),
        .flags (reg_flags)
    );

    br_cmp #(.W(W), .BIDX_W(BIDX_W)) i_cmp_imm (
        .a     (in_opa),
        .b     (in_imm_val),
        .bidx  (imm_bidx),
        .flags (imm_flags)
    );

    br_cond_sel #(.W(W)) i_sel (
        .kind      (in_kind),
        .major     (in_major),
        .reg_cond  (in_r),
        .imm_cond  (in_imm_cond),
        .zero_sel  (in_zero_sel),
        .reg_flags (reg_flags),
        .imm_flags (imm_flags),
        .opa       (in_opa),
        .taken     (taken_d),
        .illegal   (illegal_d)
    );

    br_target #(.W(W), .LONG_W(LONG_W), .SHORT_W(SHORT_W), .INSN_BYTES(4)) i_tgt (
        .pc     (in_pc),
        .disp   (in_disp),
        .wide   (wide),
        .target (target_d)
    );

    // Resolution register: verdict qualified by valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            br_taken   <= 1'b0;
            br_illegal <= 1'b0;
        end else begin
            br_taken   <= in_valid & taken_d;
            br_illegal <= in_valid & illegal_d;
        end
    end

    // Destination register: loaded only for a presented branch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            br_target <= '0;
        end else if (in_valid) begin
            br_target <= target_d;
        end
    end

    // R2
    property p_idle;
        @(posedge clk) disable iff (!rst_n) !in_valid |=> (!br_taken && !br_illegal);
    endproperty
    idle_quiet_chk: assert property (p_idle);

    // R5
    property p_bad_cond;
        @(posedge clk) disable iff (!rst_n)
            (in_valid && in_kind == BK_REG && in_r[2:1] == 2'b11) |=> (br_illegal && !br_taken);
    endproperty
    bad_cond_chk: assert property (p_bad_cond);

    // R10
    property p_excl;
        @(posedge clk) disable iff (!rst_n) br_illegal |-> !br_taken;
    endproperty
    illegal_not_taken_chk: assert property (p_excl);

    // R9
    property p_taken_src;
        @(posedge clk) disable iff (!rst_n) br_taken |-> $past(in_valid);
    endproperty
    taken_had_valid_chk: assert property (p_taken_src);

    // R6
    property p_short_reach;
        @(posedge clk) disable iff (!rst_n)
            (in_valid && in_kind != BK_ZERO)
                |=> ((br_target - $past(in_pc) + W'(124)) < W'(256));
    endproperty
    short_reach_chk: assert property (p_short_reach);

endmodule

// File: tb/test_br_eval.sv
// Directed bench for br_eval: one task per scenario, each checking itself.
module test_br_eval;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  in_kind;
    logic [3:0]  in_major;
    logic [3:0]  in_r;
    logic        in_bit4;
    logic [3:0]  in_imm_cond;
    logic [1:0]  in_zero_sel;
    logic [11:0] in_disp;
    logic [31:0] in_opa, in_opb, in_imm_val, in_pc;
    logic        br_taken, br_illegal;
    logic [31:0] br_target;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    br_eval i_br_eval (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
        .in_major(in_major), .in_r(in_r), .in_bit4(in_bit4),
        .in_imm_cond(in_imm_cond), .in_zero_sel(in_zero_sel), .in_disp(in_disp),
        .in_opa(in_opa), .in_opb(in_opb), .in_imm_val(in_imm_val), .in_pc(in_pc),
        .br_taken(br_taken), .br_target(br_target), .br_illegal(br_illegal)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Expected verdict from the requirement tables: returns {illegal, taken}
    function automatic logic [1:0] model(input logic [1:0] k, input logic [3:0] maj,
                                         input logic [3:0] r, input logic b4,
                                         input logic [3:0] ic, input logic [1:0] zs,
                                         input logic [31:0] a, input logic [31:0] b,
                                         input logic [31:0] c);
        logic [3:0]  code;
        logic [31:0] o;
        logic [4:0]  ix;
        logic        v;
        if (k == 2'd2) begin
            case (zs)
                2'd0: v = (a == 0);
                2'd1: v = (a != 0);
                2'd2: v = ($signed(a) < 0);
                default: v = ($signed(a) >= 0);
            endcase
            return {1'b0, v};
        end
        if (k == 2'd3) return 2'b10;
        if (k == 2'd0) begin
            if (maj != 4'h7) return 2'b10;
            code = r; o = b; ix = b[4:0];
            if (code[2:1] == 2'b11) return 2'b10;
        end else begin
            code = ic; o = c; ix = {b4, r};
            if (!(code[2:0] inside {3'd1, 3'd2, 3'd3, 3'd5})) return 2'b10;
        end
        case (code)
            4'h0: v = ((a & o) == 0);
            4'h1: v = (a == o);
            4'h2: v = ($signed(a) < $signed(o));
            4'h3: v = (a < o);
            4'h4: v = ((~a & o) == 0);
            4'h5: v = (a[ix] == 1'b0);
            4'h8: v = ((a & o) != 0);
            4'h9: v = (a != o);
            4'hA: v = ($signed(a) >= $signed(o));
            4'hB: v = (a >= o);
            4'hC: v = ((~a & o) != 0);
            default: v = (a[ix] == 1'b1);
        endcase
        return {1'b0, v};
    endfunction

    // Present one branch for a cycle, then compare the registered outputs
    task automatic issue(input string req, input logic [1:0] k, input logic [3:0] maj,
                         input logic [3:0] r, input logic b4, input logic [3:0] ic,
                         input logic [1:0] zs, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] c);
        logic [1:0] e;
        @(negedge clk);
        in_valid = 1'b1; in_kind = k; in_major = maj; in_r = r; in_bit4 = b4;
        in_imm_cond = ic; in_zero_sel = zs; in_opa = a; in_opb = b; in_imm_val = c;
        e = model(k, maj, r, b4, ic, zs, a, b, c);
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " taken"},   {31'd0, br_taken},   {31'd0, e[0]});
        chk({req, " illegal"}, {31'd0, br_illegal}, {31'd0, e[1]});
    endtask

    task automatic t_reset;
        rst_n = 1'b0; in_valid = 1'b1; in_kind = 2'd2; in_zero_sel = 2'd0;
        in_opa = 0; in_opb = 0; in_imm_val = 0; in_pc = 32'h40; in_disp = 12'h10;
        in_major = 4'h7; in_r = 0; in_bit4 = 0; in_imm_cond = 0;
        repeat (3) @(negedge clk);
        chk("R1 taken",   {31'd0, br_taken},   0);
        chk("R1 illegal", {31'd0, br_illegal}, 0);
        chk("R1 target",  br_target,           0);
        rst_n = 1'b1; in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_idle;
        @(negedge clk);
        in_valid = 1'b0; in_kind = 2'd3; in_opa = 0; in_zero_sel = 2'd0;
        @(negedge clk);
        chk("R2 taken idle",   {31'd0, br_taken},   0);
        chk("R2 illegal idle", {31'd0, br_illegal}, 0);
    endtask

    task automatic t_regpair;
        logic [31:0] av [4] = '{32'hFFFF_FFFF, 32'h0000_00F0, 32'h8000_0000, 32'h0000_0005};
        logic [31:0] bv [4] = '{32'h0000_0001, 32'h0000_0030, 32'h0000_001F, 32'h0000_0005};
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 16; c++) begin
                if (c[2:1] == 2'b11) continue;
                issue("R3", 2'd0, 4'h7, 4'(c), 1'b0, 4'h0, 2'd0, av[p], bv[p], 0);
            end
        end
        // masks: none vs any
        issue("R3 none", 2'd0, 4'h7, 4'h0, 1'b0, 4'h0, 2'd0, 32'hF0, 32'h0F, 0);
        issue("R3 any",  2'd0, 4'h7, 4'h8, 1'b0, 4'h0, 2'd0, 32'hF0, 32'h0F, 0);
    endtask

    task automatic t_bitidx;
        // B upper bits set; index is low five bits only
        issue("R4 set hi",   2'd0, 4'h7, 4'hD, 1'b0, 4'h0, 2'd0, 32'h8000_0000, 32'hFFFF_FFFF, 0);
        issue("R4 clr hi",   2'd0, 4'h7, 4'h5, 1'b0, 4'h0, 2'd0, 32'h8000_0000, 32'h0000_0FE0, 0);
        issue("R4 set bit3", 2'd0, 4'h7, 4'hD, 1'b0, 4'h0, 2'd0, 32'h0000_0008, 32'h0000_0123, 0);
    endtask

    task automatic t_illegal;
        logic [3:0] codes [4] = '{4'h6, 4'h7, 4'hE, 4'hF};
        for (int i = 0; i < 4; i++)
            issue("R5", 2'd0, 4'h7, codes[i], 1'b0, 4'h0, 2'd0, 32'h1, 32'h1, 0);
        issue("R10 major", 2'd0, 4'h6, 4'h1, 1'b0, 4'h0, 2'd0, 32'h3, 32'h3, 0);
        issue("R10 rsvd",  2'd3, 4'h7, 4'h1, 1'b0, 4'h1, 2'd0, 32'h3, 32'h3, 32'h3);
    endtask

    task automatic tgt(input string req, input logic [1:0] k, input logic [11:0] d,
                       input logic [31:0] pc, input logic [31:0] exp);
        @(negedge clk);
        in_valid = 1'b1; in_kind = k; in_major = 4'h7; in_r = 4'h1; in_imm_cond = 4'h1;
        in_zero_sel = 2'd0; in_disp = d; in_pc = pc; in_opa = 0; in_opb = 0; in_imm_val = 0;
        @(negedge clk);
        in_valid = 1'b0;
        chk(req, br_target, exp);
    endtask

    task automatic t_targets;
        tgt("R6 min",     2'd0, 12'h080, 32'h1000, 32'h0000_0F84);
        tgt("R6 max",     2'd1, 12'h07F, 32'h1000, 32'h0000_1083);
        tgt("R6 hi nib",  2'd0, 12'hF05, 32'h1000, 32'h0000_1009);
        tgt("R7 min",     2'd2, 12'h800, 32'h1000, 32'h0000_0804);
        tgt("R7 max",     2'd2, 12'h7FF, 32'h1000, 32'h0000_1803);
        tgt("R7 zero",    2'd2, 12'h000, 32'hFFFF_FFFC, 32'h0000_0000);
    endtask

    task automatic t_zero;
        logic [31:0] av [3] = '{32'h0, 32'h8000_0000, 32'h0000_0007};
        for (int i = 0; i < 3; i++)
            for (int z = 0; z < 4; z++)
                issue("R7", 2'd2, 4'h0, 4'h0, 1'b0, 4'h0, 2'(z), av[i], 32'h0, 0);
    endtask

    task automatic t_imm;
        for (int c = 0; c < 16; c++) begin
            issue("R8 cmp",  2'd1, 4'h6, 4'h3, 1'b1, 4'(c), 2'd0, 32'hFFFF_FFFF, 32'h0, 32'h1);
            issue("R8 eq",   2'd1, 4'h6, 4'h0, 1'b0, 4'(c), 2'd0, 32'h10, 32'h0, 32'h10);
        end
        // bit position {bit4, r} = 19
        issue("R8 bitset", 2'd1, 4'h6, 4'h3, 1'b1, 4'hD, 2'd0, 32'h0008_0000, 32'h0, 0);
        issue("R8 bitclr", 2'd1, 4'h6, 4'h3, 1'b1, 4'h5, 2'd0, 32'h0008_0000, 32'h0, 0);
        issue("R8 bit3",   2'd1, 4'h6, 4'h3, 1'b0, 4'hD, 2'd0, 32'h0008_0000, 32'h0, 0);
    endtask

    task automatic t_back2back;
        // two branches in consecutive cycles, opposite verdicts
        @(negedge clk);
        in_valid = 1'b1; in_kind = 2'd0; in_major = 4'h7; in_r = 4'h1;
        in_opa = 32'h5; in_opb = 32'h5; in_disp = 12'h010; in_pc = 32'h2000;
        @(negedge clk);
        chk("R9 first taken",  {31'd0, br_taken}, 1);
        chk("R9 first target", br_target, 32'h0000_2014);
        in_r = 4'h9; in_pc = 32'h3000;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9 second taken",  {31'd0, br_taken}, 0);
        chk("R9 second target", br_target, 32'h0000_3014);
        @(negedge clk);
        chk("R9 after idle", {31'd0, br_taken}, 0);
        chk("R9 target hold", br_target, 32'h0000_3014);
    endtask

    initial begin
        #(200000 * 10);
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_idle();
        t_regpair();
        t_bitidx();
        t_illegal();
        t_targets();
        t_zero();
        t_imm();
        t_back2back();
        t_idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule